// File: doc/BRIEF.md
# Nested Trap Entry Controller

This block performs the state update that a processor with a multi-level trap stack carries out when it accepts a trap. A single-cycle strobe presents the trap type together with the current program counter, next program counter, processor-state word, trap base address, current window pointer and the count of windows that can still be saved. On the clock edge that samples the strobe, the block does several things. It steps its internal trap level, or enters a sticky error state when the stack is already full. It issues a write of the saved context into the trap-stack entry selected by the new level. It replaces the processor-state word according to the class of the trap. It moves the window pointer for window-management traps. It computes the vector address and the address that follows it.

The trap-stack storage sits outside the block. It receives a one-cycle write pulse with the index, the saved state and the saved addresses. The updated processor registers are held in the block and are presented on its outputs. A done pulse marks every accepted strobe, including one that runs into the error state.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A strobe that arrives while the trap level equals MAXTL (default 5) sets err_o. It issues no stack write and leaves tl_o, pc_o, npc_o, pstate_o and cwp_o unchanged. err_o stays set until reset, and later strobes are ignored in the same way.
- R2: A strobe at a trap level below MAXTL raises tl_o by one. The level starts at 0 after reset.
- R3: pstate_o bit 5 (RED) is set after an accepted trap exactly when the level before the trap was MAXTL-1 or higher. Otherwise it is clear.
- R4: An accepted trap pulses ts_we_o for one cycle. In that cycle ts_idx_o equals the new level, ts_tstate_o equals {pstate_i, cwp_i}, and ts_tpc_o, ts_tnpc_o and ts_tt_o equal pc_i, npc_i and the trap type.
- R5: pc_o is formed from tba_i with bits 14:0 cleared. Bit 14 is set when the new level exceeds 1, and the 9-bit trap type occupies bits 13:5.
- R6: npc_o equals pc_o plus 4.
- R7: The new pstate_o is PEF (bit 4) plus PRIV (bit 2) plus one global-select bit, with all other bits clear apart from R3's bit 5. The select bit depends on the trap type. Type 0x060 uses bit 11. Types 0x008 and 0x030, and types 0x064 to 0x06F, use bit 10. All other types use bit 0.
- R8: Trap type 0x024 sets cwp_o to cwp_i-1, modulo NWIN (default 8).
- R9: A trap type whose bits 8:6 are 010 sets cwp_o to cwp_i - cansave_i - 2, modulo NWIN.
- R10: A trap type whose bits 8:6 are 011 sets cwp_o to cwp_i + 1, modulo NWIN.
- R11: Any other accepted trap sets cwp_o to cwp_i.
- R12: All outputs change on the edge that samples trap_valid_i high. done_o is high for exactly the following cycle. With trap_valid_i low, no register changes and done_o and ts_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid_i | input | 1 | One-cycle trap acceptance strobe |
| trap_type_i | input | 9 | Trap type code |
| pc_i | input | ADDR_W | Program counter at the trap |
| npc_i | input | ADDR_W | Next program counter at the trap |
| pstate_i | input | PS_W | Processor-state word at the trap |
| tba_i | input | ADDR_W | Trap base address |
| cwp_i | input | WP_W | Current window pointer |
| cansave_i | input | WP_W | Windows that can still be saved |
| tl_o | output | TL_W | Current trap level |
| err_o | output | 1 | Sticky error state |
| pc_o | output | ADDR_W | Vector address |
| npc_o | output | ADDR_W | Address following the vector |
| pstate_o | output | PS_W | New processor-state word |
| cwp_o | output | WP_W | New window pointer |
| done_o | output | 1 | Pulse one cycle after each strobe |
| ts_we_o | output | 1 | Trap-stack write pulse |
| ts_idx_o | output | TL_W | Trap-stack entry index |
| ts_tstate_o | output | PS_W+WP_W | Saved state and window pointer |
| ts_tpc_o | output | ADDR_W | Saved program counter |
| ts_tnpc_o | output | ADDR_W | Saved next program counter |
| ts_tt_o | output | 9 | Saved trap type |

## Verification
The bench targets the level boundaries. The step from MAXTL-1 to MAXTL must set the RED bit while the lower steps must not, and a strobe at MAXTL must freeze every register and suppress the stack write. A design that compared against the wrong limit would either raise RED one level early or write beyond the last stack entry. The bench also checks window-pointer wrap in both directions, from 0 down on a clean-window trap and from 7 up on a fill, and a spill whose subtraction goes negative. A design without correct modulo handling would return an out-of-range or off-by-one pointer there. The nested vector bit is checked on the first trap, where it must be clear, and on the second, where it must be set, so that keying it on the old level rather than the new one is caught.

// File: rtl/trap_entry_pkg.sv
// Package: shared constants and types for the trap entry controller.
// Assumes a 9-bit trap type and a 15-bit vector field inside the base address.
package trap_entry_pkg;

    localparam int TT_W      = 9;
    localparam int VEC_SHIFT = 5;
    localparam int VEC_LOW   = 15;   // base address bits below this are replaced

    // processor-state bit positions
    localparam int PSB_AG   = 0;
    localparam int PSB_PRIV = 2;
    localparam int PSB_PEF  = 4;
    localparam int PSB_RED  = 5;
    localparam int PSB_MG   = 10;
    localparam int PSB_IG   = 11;

    // specific trap type codes
    localparam logic [TT_W-1:0] TT_IVEC    = 9'h060;
    localparam logic [TT_W-1:0] TT_IFAULT  = 9'h008;
    localparam logic [TT_W-1:0] TT_DFAULT  = 9'h030;
    localparam logic [TT_W-1:0] TT_CLEANW  = 9'h024;
    localparam logic [TT_W-3:0] TT_MMU_LO  = 7'h19;  // 0x064..0x067
    localparam logic [TT_W-3:0] TT_MMU_MID = 7'h1A;  // 0x068..0x06B
    localparam logic [TT_W-3:0] TT_MMU_HI  = 7'h1B;  // 0x06C..0x06F
    localparam logic [2:0]      TT_SPILL_G = 3'b010;
    localparam logic [2:0]      TT_FILL_G  = 3'b011;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_IVEC  = 2'd1,
        CLS_MMU   = 2'd2
    } trap_class_e;

    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_DEC1  = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_INC1  = 2'd3
    } win_op_e;

endpackage

// File: rtl/trap_classify.sv
// Module: decodes a trap type into a state-bit class and a window-pointer action.
// Assumes the type codes in trap_entry_pkg; purely combinational.
module trap_classify
    import trap_entry_pkg::*;
(
    input  logic [TT_W-1:0] tt_i,
    output trap_class_e     cls_o,
    output win_op_e         win_op_o
);

    logic [TT_W-3:0] tt_quad;
    assign tt_quad = tt_i[TT_W-1:2];

    // pick the state-bit class of the trap
    always_comb begin
        if (tt_i == TT_IVEC) begin
            cls_o = CLS_IVEC;
        end else if (tt_i == TT_IFAULT || tt_i == TT_DFAULT ||
                     tt_quad == TT_MMU_LO || tt_quad == TT_MMU_MID ||
                     tt_quad == TT_MMU_HI) begin
            cls_o = CLS_MMU;
        end else begin
            cls_o = CLS_OTHER;
        end
    end

    // pick the window-pointer action of the trap
    always_comb begin
        if (tt_i == TT_CLEANW) begin
            win_op_o = WIN_DEC1;
        end else if (tt_i[TT_W-1:6] == TT_SPILL_G) begin
            win_op_o = WIN_SPILL;
        end else if (tt_i[TT_W-1:6] == TT_FILL_G) begin
            win_op_o = WIN_INC1;
        end else begin
            win_op_o = WIN_KEEP;
        end
    end

endmodule

// File: rtl/trap_level_step.sv
// Module: decides whether a trap is taken and computes the next trap level.
// Assumes the error state is only reachable with the level at MAXTL.
module trap_level_step #(
    parameter int MAXTL = 5,
    parameter int TL_W  = $clog2(MAXTL + 1)
) (
    input  logic [TL_W-1:0] tl_i,
    input  logic            err_i,
    output logic            take_o,
    output logic [TL_W-1:0] tl_next_o,
    output logic            red_o
);

    localparam logic [TL_W-1:0] TL_MAX  = TL_W'(MAXTL);
    localparam logic [TL_W-1:0] TL_EDGE = TL_W'(MAXTL - 1);
    localparam logic [TL_W-1:0] TL_ONE  = TL_W'(1);

    // the trap is taken only while the stack still has room
    assign take_o = !err_i && (tl_i < TL_MAX);

    // step the level and flag the reset/error-entry state near the limit
    always_comb begin
        tl_next_o = tl_i;
        red_o     = 1'b0;
        if (tl_i < TL_EDGE) begin
            tl_next_o = tl_i + TL_ONE;
        end else begin
            red_o = 1'b1;
            if (tl_i < TL_MAX) begin
                tl_next_o = tl_i + TL_ONE;
            end
        end
    end

endmodule

// File: rtl/cwp_adjust.sv
// Module: computes the new window pointer for window-management traps.
// Assumes cansave_i < NWIN; works for any window count, not only powers of two.
module cwp_adjust
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [WP_W-1:0] cwp_i,
    input  logic [WP_W-1:0] cansave_i,
    input  win_op_e         op_i,
    output logic [WP_W-1:0] cwp_o
);

    localparam int SUM_W = WP_W + 3;
    localparam logic [SUM_W-1:0] N1 = SUM_W'(NWIN);
    localparam logic [SUM_W-1:0] N2 = SUM_W'(2 * NWIN);

    logic [SUM_W-1:0] cwp_w;
    logic [SUM_W-1:0] cs_w;
    logic [SUM_W-1:0] raw;
    logic [SUM_W-1:0] wrapped;

    assign cwp_w = SUM_W'(cwp_i);
    assign cs_w  = SUM_W'(cansave_i);

    // form a non-negative offset sum for the selected action
    always_comb begin
        case (op_i)
            WIN_DEC1:  raw = cwp_w + N1 - SUM_W'(1);
            WIN_SPILL: raw = cwp_w + N2 - cs_w - SUM_W'(2);
            WIN_INC1:  raw = cwp_w + SUM_W'(1);
            default:   raw = cwp_w;
        endcase
    end

    // reduce the sum into the window range
    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            assign wrapped = raw & (N1 - SUM_W'(1));
        end else begin : g_general
            assign wrapped = raw % N1;
        end
    endgenerate

    assign cwp_o = wrapped[WP_W-1:0];

endmodule

// File: rtl/trap_vector.sv
// Module: builds the vector address and its successor from the trap base.
// Assumes ADDR_W > 15 and a 9-bit trap type placed at bit 5.
module trap_vector
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] tba_i,
    input  logic [TT_W-1:0]   tt_i,
    input  logic              nested_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o
);

    // splice nesting bit and trap type into the cleared low field
    assign pc_o  = {tba_i[ADDR_W-1:VEC_LOW], nested_i, tt_i, {VEC_SHIFT{1'b0}}};

    // the successor address is one instruction later
    assign npc_o = pc_o + ADDR_W'(4);

endmodule

// File: rtl/trap_entry_ctrl.sv
// Module: top of the trap entry controller. Holds trap level, error flag and
// the updated processor registers; issues one trap-stack write per taken trap.
// Assumes trap_valid_i is a single-cycle strobe and the stack lives outside.
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PS_W   = 12,
    parameter int MAXTL  = 5,
    parameter int NWIN   = 8,
    parameter int TL_W   = $clog2(MAXTL + 1),
    parameter int WP_W   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trap_valid_i,
    input  logic [8:0]           trap_type_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [ADDR_W-1:0]    npc_i,
    input  logic [PS_W-1:0]      pstate_i,
    input  logic [ADDR_W-1:0]    tba_i,
    input  logic [WP_W-1:0]      cwp_i,
    input  logic [WP_W-1:0]      cansave_i,
    output logic [TL_W-1:0]      tl_o,
    output logic                 err_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [ADDR_W-1:0]    npc_o,
    output logic [PS_W-1:0]      pstate_o,
    output logic [WP_W-1:0]      cwp_o,
    output logic                 done_o,
    output logic                 ts_we_o,
    output logic [TL_W-1:0]      ts_idx_o,
    output logic [PS_W+WP_W-1:0] ts_tstate_o,
    output logic [ADDR_W-1:0]    ts_tpc_o,
    output logic [ADDR_W-1:0]    ts_tnpc_o,
    output logic [8:0]           ts_tt_o
);

    localparam int TS_W = PS_W + WP_W;
    localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

    trap_class_e       cls;
    win_op_e           win_op;
    logic              take;
    logic              red;
    logic [TL_W-1:0]   tl_next;
    logic [WP_W-1:0]   cwp_next;
    logic [ADDR_W-1:0] vec_pc;
    logic [ADDR_W-1:0] vec_npc;
    logic [PS_W-1:0]   ps_next;

    trap_classify u_classify (
        .tt_i     (trap_type_i),
        .cls_o    (cls),
        .win_op_o (win_op)
    );

    trap_level_step #(.MAXTL(MAXTL), .TL_W(TL_W)) u_level (
        .tl_i      (tl_o),
        .err_i     (err_o),
        .take_o    (take),
        .tl_next_o (tl_next),
        .red_o     (red)
    );

    cwp_adjust #(.NWIN(NWIN), .WP_W(WP_W)) u_cwp (
        .cwp_i     (cwp_i),
        .cansave_i (cansave_i),
        .op_i      (win_op),
        .cwp_o     (cwp_next)
    );

    trap_vector #(.ADDR_W(ADDR_W)) u_vector (
        .tba_i    (tba_i),
        .tt_i     (trap_type_i),
        .nested_i (tl_next > TL_ONE),
        .pc_o     (vec_pc),
        .npc_o    (vec_npc)
    );

    // compose the replacement processor-state word for the trap class
    always_comb begin
        ps_next           = '0;
        ps_next[PSB_PEF]  = 1'b1;
        ps_next[PSB_PRIV] = 1'b1;
        ps_next[PSB_RED]  = red;
        case (cls)
            CLS_IVEC: ps_next[PSB_IG] = 1'b1;
            CLS_MMU:  ps_next[PSB_MG] = 1'b1;
            default:  ps_next[PSB_AG] = 1'b1;
        endcase
    end

    // register the trap entry: level, error, processor registers, stack write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_o        <= '0;
            err_o       <= 1'b0;
            pc_o        <= '0;
            npc_o       <= '0;
            pstate_o    <= '0;
            cwp_o       <= '0;
            done_o      <= 1'b0;
            ts_we_o     <= 1'b0;
            ts_idx_o    <= '0;
            ts_tstate_o <= '0;
            ts_tpc_o    <= '0;
            ts_tnpc_o   <= '0;
            ts_tt_o     <= '0;
        end else begin
            done_o  <= trap_valid_i;
            ts_we_o <= 1'b0;
            if (trap_valid_i) begin
                if (take) begin
                    tl_o        <= tl_next;
                    pc_o        <= vec_pc;
                    npc_o       <= vec_npc;
                    pstate_o    <= ps_next;
                    cwp_o       <= cwp_next;
                    ts_we_o     <= 1'b1;
                    ts_idx_o    <= tl_next;
                    ts_tstate_o <= TS_W'({pstate_i, cwp_i});
                    ts_tpc_o    <= pc_i;
                    ts_tnpc_o   <= npc_i;
                    ts_tt_o     <= trap_type_i;
                end else begin
                    err_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
// Checker: temporal properties of the trap entry controller, bound to the top.
// Assumes default-compatible parameters passed through the bind.
module trap_entry_ctrl_chk #(
    parameter int ADDR_W = 64,
    parameter int PS_W   = 12,
    parameter int MAXTL  = 5,
    parameter int NWIN   = 8,
    parameter int TL_W   = $clog2(MAXTL + 1),
    parameter int WP_W   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_valid_i,
    input logic [TL_W-1:0]   tl_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic [PS_W-1:0]   pstate_o,
    input logic              done_o,
    input logic              ts_we_o,
    input logic [TL_W-1:0]   ts_idx_o
);

    localparam logic [TL_W-1:0] TL_MAX = TL_W'(MAXTL);
    localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o && $stable(tl_o) && $stable(pc_o) && !ts_we_o); // R1

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !err_o && tl_o < TL_MAX) |=> (tl_o == $past(tl_o) + TL_ONE)); // R2

    AST_RED_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we_o |-> (pstate_o[5] == (tl_o == TL_MAX))); // R3

    AST_STACK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we_o |-> (ts_idx_o == tl_o)); // R4

    AST_NEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we_o |-> (pc_o[14] == (tl_o > TL_ONE))); // R5

    AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we_o |-> (npc_o == pc_o + ADDR_W'(4))); // R6

    AST_ONE_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        ts_we_o |-> (pstate_o[4] && pstate_o[2] &&
                     $countones({pstate_o[11], pstate_o[10], pstate_o[0]}) == 1)); // R7

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_i |=> done_o); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid_i |=> (!done_o && !ts_we_o && $stable(tl_o) && $stable(pc_o))); // R12

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(
    .ADDR_W(ADDR_W), .PS_W(PS_W), .MAXTL(MAXTL), .NWIN(NWIN), .TL_W(TL_W), .WP_W(WP_W)
) u_trap_entry_ctrl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_valid_i (trap_valid_i),
    .tl_o         (tl_o),
    .err_o        (err_o),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .pstate_o     (pstate_o),
    .done_o       (done_o),
    .ts_we_o      (ts_we_o),
    .ts_idx_o     (ts_idx_o)
);

// File: tb/trap_entry_ctrl_bench.sv
// Directed bench for trap_entry_ctrl: one task per scenario, each self-checking.
module trap_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid_i = 1'b0;
    logic [8:0]  trap_type_i = '0;
    logic [63:0] pc_i = '0;
    logic [63:0] npc_i = '0;
    logic [11:0] pstate_i = '0;
    logic [63:0] tba_i = '0;
    logic [2:0]  cwp_i = '0;
    logic [2:0]  cansave_i = '0;
    logic [2:0]  tl_o;
    logic        err_o;
    logic [63:0] pc_o;
    logic [63:0] npc_o;
    logic [11:0] pstate_o;
    logic [2:0]  cwp_o;
    logic        done_o;
    logic        ts_we_o;
    logic [2:0]  ts_idx_o;
    logic [14:0] ts_tstate_o;
    logic [63:0] ts_tpc_o;
    logic [63:0] ts_tnpc_o;
    logic [8:0]  ts_tt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    trap_entry_ctrl u_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid_i),
        .trap_type_i(trap_type_i), .pc_i(pc_i), .npc_i(npc_i),
        .pstate_i(pstate_i), .tba_i(tba_i), .cwp_i(cwp_i), .cansave_i(cansave_i),
        .tl_o(tl_o), .err_o(err_o), .pc_o(pc_o), .npc_o(npc_o),
        .pstate_o(pstate_o), .cwp_o(cwp_o), .done_o(done_o), .ts_we_o(ts_we_o),
        .ts_idx_o(ts_idx_o), .ts_tstate_o(ts_tstate_o), .ts_tpc_o(ts_tpc_o),
        .ts_tnpc_o(ts_tnpc_o), .ts_tt_o(ts_tt_o)
    );

    always #2.5 clk = ~clk;

    // watchdog: a hung run is counted as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_vec(input logic [63:0] tba, input logic [8:0] tt,
                                            input int new_tl);
        logic [63:0] v;
        v = tba & ~64'h7fff;
        if (new_tl > 1) v = v | 64'h4000;
        v = v | (64'(tt) << 5);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trap_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // pulse one trap strobe; returns at the negedge after the sampling edge
    task automatic fire(input logic [8:0] tt, input logic [2:0] cwp, input logic [2:0] cs);
        trap_type_i  = tt;
        cwp_i        = cwp;
        cansave_i    = cs;
        trap_valid_i = 1'b1;
        @(negedge clk);
        trap_valid_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R2 reset level", 64'(tl_o), 64'd0);
        chk("R1 reset err", 64'(err_o), 64'd0);
        chk("R12 reset done", 64'(done_o), 64'd0);
        chk("R12 reset we", 64'(ts_we_o), 64'd0);
    endtask

    task automatic t_first_and_nested();
        do_reset();
        tba_i = 64'h0000_1234_5678_9abc;
        pc_i = 64'h0000_0000_0040_1000;
        npc_i = 64'h0000_0000_0040_1004;
        pstate_i = 12'h0a5;
        fire(9'h041, 3'd3, 3'd2);
        chk("R2 first level", 64'(tl_o), 64'd1);
        chk("R5 first vector", pc_o, exp_vec(tba_i, 9'h041, 1));
        chk("R6 first next", npc_o, exp_vec(tba_i, 9'h041, 1) + 64'd4);
        chk("R7 other class", 64'(pstate_o), 64'h015);
        chk("R11 keep cwp", 64'(cwp_o), 64'd3);
        chk("R4 we", 64'(ts_we_o), 64'd1);
        chk("R4 idx", 64'(ts_idx_o), 64'd1);
        chk("R4 tstate", 64'(ts_tstate_o), 64'({12'h0a5, 3'd3}));
        chk("R4 tpc", ts_tpc_o, pc_i);
        chk("R4 tnpc", ts_tnpc_o, npc_i);
        chk("R4 tt", 64'(ts_tt_o), 64'h041);
        chk("R12 done", 64'(done_o), 64'd1);
        pc_i = 64'h0000_0000_0000_2220;
        fire(9'h060, 3'd5, 3'd0);
        chk("R2 nested level", 64'(tl_o), 64'd2);
        chk("R5 nested vector", pc_o, exp_vec(tba_i, 9'h060, 2));
        chk("R7 ivec class", 64'(pstate_o), 64'h814);
        chk("R4 nested idx", 64'(ts_idx_o), 64'd2);
        @(negedge clk);
        chk("R12 done falls", 64'(done_o), 64'd0);
        chk("R12 we falls", 64'(ts_we_o), 64'd0);
        chk("R12 idle level", 64'(tl_o), 64'd2);
    endtask

    task automatic t_mmu_classes();
        do_reset();
        fire(9'h068, 3'd1, 3'd0);
        chk("R7 mmu miss class", 64'(pstate_o), 64'h414);
        fire(9'h008, 3'd1, 3'd0);
        chk("R7 ifault class", 64'(pstate_o), 64'h414);
        fire(9'h06f, 3'd1, 3'd0);
        chk("R7 prot class", 64'(pstate_o), 64'h414);
        fire(9'h070, 3'd1, 3'd0);
        chk("R7 past mmu range", 64'(pstate_o), 64'h015);
    endtask

    task automatic t_windows();
        do_reset();
        fire(9'h024, 3'd0, 3'd4);
        chk("R8 clean wrap", 64'(cwp_o), 64'd7);
        fire(9'h084, 3'd2, 3'd5);
        chk("R9 spill negative", 64'(cwp_o), 64'd3);
        fire(9'h0bc, 3'd7, 3'd0);
        chk("R9 spill zero cansave", 64'(cwp_o), 64'd5);
        fire(9'h0c0, 3'd7, 3'd3);
        chk("R10 fill wrap", 64'(cwp_o), 64'd0);
        do_reset();
        fire(9'h0ff, 3'd3, 3'd3);
        chk("R10 fill plain", 64'(cwp_o), 64'd4);
        fire(9'h100, 3'd6, 3'd1);
        chk("R11 trap insn keep", 64'(cwp_o), 64'd6);
    endtask

    task automatic t_red_and_error();
        logic [63:0] held_pc;
        do_reset();
        tba_i = 64'h0000_0000_0010_0000;
        for (int i = 1; i <= 4; i++) begin
            fire(9'h041, 3'd2, 3'd0);
            chk("R3 no red below edge", 64'(pstate_o[5]), 64'd0);
        end
        chk("R2 level four", 64'(tl_o), 64'd4);
        fire(9'h042, 3'd2, 3'd0);
        chk("R2 level max", 64'(tl_o), 64'd5);
        chk("R3 red at edge", 64'(pstate_o), 64'h035);
        chk("R4 last idx", 64'(ts_idx_o), 64'd5);
        held_pc = pc_o;
        fire(9'h024, 3'd4, 3'd0);
        chk("R1 err set", 64'(err_o), 64'd1);
        chk("R1 no write", 64'(ts_we_o), 64'd0);
        chk("R1 level held", 64'(tl_o), 64'd5);
        chk("R1 pc held", pc_o, held_pc);
        chk("R1 cwp held", 64'(cwp_o), 64'd2);
        chk("R12 done on error", 64'(done_o), 64'd1);
        fire(9'h060, 3'd1, 3'd0);
        chk("R1 err sticky", 64'(err_o), 64'd1);
        chk("R1 pstate held", 64'(pstate_o), 64'h035);
        chk("R1 still no write", 64'(ts_we_o), 64'd0);
    endtask

    initial begin
        t_reset_state();
        t_first_and_nested();
        t_mmu_classes();
        t_windows();
        t_red_and_error();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule